// File: doc/BRIEF.md
# LED Blink Status Code Encoder

This block shows a small numeric status value on a single indicator LED. While a report flag is held high, it sends the value out one bit at a time, least significant bit first. Each bit becomes one lit pulse: a short pulse for a 0 and a long pulse for a 1. Dark gaps of fixed length separate the bits. A longer dark interval follows the last bit, and then the whole value is sent again. When there is nothing to report, the LED stays off.

All timing is counted in units. A unit is one period of a clock-enable tick from a free-running prescaler on the system clock. The value is captured when each frame begins, so changing the input part-way through a frame has no effect on that frame.

The sequencer is a four-state machine:

| State | LED | Leaves when | Goes to |
|---|---|---|---|
| IDLE | off | a tick arrives with the flag high | PULSE, capturing the value |
| PULSE | on | its units have run out, not on the last bit | GAP |
| PULSE | on | its units have run out, on the last bit | DEAD |
| GAP | off | its units have run out | PULSE, for the next bit |
| DEAD | off | its units have run out, flag high | PULSE, capturing a new value |
| DEAD | off | its units have run out, flag low | IDLE |

Top module: `led_code_blinker`

## Requirements
- R1: A synchronous active-high reset sends the sequencer to IDLE with the LED off. The LED is off at the first falling clock edge after any rising edge at which reset is high.
- R2: One unit equals PRESCALE clock cycles. Ticks fall every PRESCALE cycles, counted from the release of reset. The LED changes only on the clock edge at which a tick is active.
- R3: Bits are sent least significant bit first. For example, value 4'b0001 gives a long first pulse, and value 4'b0100 gives a long third pulse.
- R4: A 0 bit lights the LED for SHORT_UNITS units (default 1). A 1 bit lights it for LONG_UNITS units (default 3).
- R5: Between the pulses of consecutive bits, the LED is dark for GAP_UNITS units (default 3).
- R6: After the fourth pulse, the LED is dark for DEAD_UNITS units (default 12). If the flag is still high at that point, the next frame starts at once.
- R7: While the flag is low and no frame is in progress, the LED stays off.
- R8: The value is captured at the tick that starts each frame. Changes to the input during a frame have no effect until the next frame.
- R9: When the flag drops during a frame, the frame is completed, including its dead time. The block then returns to IDLE with the LED off.
- R10: From IDLE, the first pulse begins at the first tick at which the flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Report flag: a condition is present and should be shown |
| code | input | CODE_W | Value to blink |
| led | output | 1 | LED drive, high means lit |

## Verification
The bench changes the input value in the middle of a frame. A design that captured the value too late would send a pulse of the wrong width partway through the frame. The bench also drops the flag mid-frame. A design that stopped early would cut the frame short, and one that ignored the drop would start another frame. Values with the set bit at the first and third positions catch a reversed bit order or swapped pulse widths. Checking every cycle against the bench's model catches a gap or dead interval that is off by one unit, or a tick period that is wrong.

// File: rtl/led_code_pkg.sv
package led_code_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_PULSE = 2'd1,
        S_GAP   = 2'd2,
        S_DEAD  = 2'd3
    } blink_state_t;
endpackage

// File: rtl/blink_prescaler.sv
module blink_prescaler #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || cnt == LAST) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    generate
        if (PRESCALE > 1) begin : g_spacing
            // R2: two ticks never fall on adjacent cycles
            a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/blink_sequencer.sv
module blink_sequencer
    import led_code_pkg::*;
#(
    parameter int CODE_W      = 4,
    parameter int SHORT_UNITS = 1,
    parameter int LONG_UNITS  = 3,
    parameter int GAP_UNITS   = 3,
    parameter int DEAD_UNITS  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    output logic              led
);
    localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
    localparam int MAX_A = (SHORT_UNITS > LONG_UNITS) ? SHORT_UNITS : LONG_UNITS;
    localparam int MAX_B = (GAP_UNITS > DEAD_UNITS) ? GAP_UNITS : DEAD_UNITS;
    localparam int MAX_U = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAX_U + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CODE_W - 1);

    blink_state_t      state, state_n;
    logic [IDX_W-1:0]  idx, idx_n;
    logic [CNT_W-1:0]  rem, rem_n;
    logic [CODE_W-1:0] code_q, code_q_n;

    function automatic logic [CNT_W-1:0] pulse_len(input logic b);
        return b ? CNT_W'(LONG_UNITS - 1) : CNT_W'(SHORT_UNITS - 1);
    endfunction

    always_comb begin
        state_n  = state;
        idx_n    = idx;
        rem_n    = rem;
        code_q_n = code_q;
        if (tick) begin
            unique case (state)
                S_IDLE: begin
                    if (en) begin
                        code_q_n = code;
                        idx_n    = '0;
                        rem_n    = pulse_len(code[0]);
                        state_n  = S_PULSE;
                    end
                end
                S_PULSE: begin
                    if (rem != '0) begin
                        rem_n = rem - 1'b1;
                    end else if (idx == LAST_IDX) begin
                        rem_n   = CNT_W'(DEAD_UNITS - 1);
                        state_n = S_DEAD;
                    end else begin
                        rem_n   = CNT_W'(GAP_UNITS - 1);
                        state_n = S_GAP;
                    end
                end
                S_GAP: begin
                    if (rem != '0) begin
                        rem_n = rem - 1'b1;
                    end else begin
                        idx_n   = idx + 1'b1;
                        rem_n   = pulse_len(code_q[idx_n]);
                        state_n = S_PULSE;
                    end
                end
                S_DEAD: begin
                    if (rem != '0) begin
                        rem_n = rem - 1'b1;
                    end else if (en) begin
                        code_q_n = code;
                        idx_n    = '0;
                        rem_n    = pulse_len(code[0]);
                        state_n  = S_PULSE;
                    end else begin
                        state_n = S_IDLE;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            idx    <= '0;
            rem    <= '0;
            code_q <= '0;
        end else begin
            state  <= state_n;
            idx    <= idx_n;
            rem    <= rem_n;
            code_q <= code_q_n;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) led <= 1'b0;
        else     led <= (state_n == S_PULSE);
    end

    // R1: reset leaves the machine idle and dark
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (state == S_IDLE && !led && idx == '0));
    // R2: nothing moves between ticks
    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(state) && $stable(rem) && $stable(idx)));
    // R3: bits advance in ascending order
    a_r3_next_bit: assert property (@(posedge clk) disable iff (rst)
        (tick && state == S_GAP && rem == '0) |=>
            (state == S_PULSE && idx == $past(idx) + 1'b1));
    // R6: the last pulse leads into the dead interval
    a_r6_dead_after_last: assert property (@(posedge clk) disable iff (rst)
        (tick && state == S_PULSE && rem == '0 && idx == LAST_IDX) |=> (state == S_DEAD));
    // R8: captured value holds for the whole frame
    a_r8_code_held: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE && !(tick && state == S_DEAD && rem == '0)) |=> $stable(code_q));
    // R9: a dropped flag ends in IDLE after the dead interval
    a_r9_idle_after_drop: assert property (@(posedge clk) disable iff (rst)
        (tick && state == S_DEAD && rem == '0 && !en) |=> (state == S_IDLE && !led));
endmodule

// File: rtl/led_code_blinker.sv
module led_code_blinker #(
    parameter int CODE_W      = 4,
    parameter int PRESCALE    = 4,
    parameter int SHORT_UNITS = 1,
    parameter int LONG_UNITS  = 3,
    parameter int GAP_UNITS   = 3,
    parameter int DEAD_UNITS  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    output logic              led
);
    logic tick;

    blink_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    blink_sequencer #(
        .CODE_W      (CODE_W),
        .SHORT_UNITS (SHORT_UNITS),
        .LONG_UNITS  (LONG_UNITS),
        .GAP_UNITS   (GAP_UNITS),
        .DEAD_UNITS  (DEAD_UNITS)
    ) u_seq (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .en   (en),
        .code (code),
        .led  (led)
    );
endmodule

// File: tb/test_led_code_blinker.sv
module test_led_code_blinker;
    localparam int CLK_PERIOD = 10;
    localparam int P  = 3;
    localparam int SU = 1;
    localparam int LU = 3;
    localparam int GU = 3;
    localparam int DU = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [3:0] code = 4'd0;
    logic       led;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    led_code_blinker #(
        .CODE_W(4), .PRESCALE(P), .SHORT_UNITS(SU), .LONG_UNITS(LU),
        .GAP_UNITS(GAP_UNITS_F()), .DEAD_UNITS(DU)
    ) i_led_code_blinker (
        .clk(clk), .rst(rst), .en(en), .code(code), .led(led)
    );

    function automatic int GAP_UNITS_F();
        return GU;
    endfunction

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference: a queue of per-unit LED levels, refilled per frame
    bit exp_led = 1'b0;
    bit unit_q[$];
    int pc = 0;

    always @(posedge clk) begin
        if (rst) begin
            pc = 0;
            exp_led = 1'b0;
            unit_q.delete();
        end else if (pc == P - 1) begin
            pc = 0;
            if (unit_q.size() == 0 && en) begin
                for (int b = 0; b < 4; b++) begin
                    for (int u = 0; u < (code[b] ? LU : SU); u++) unit_q.push_back(1'b1);
                    if (b < 3) for (int u = 0; u < GU; u++) unit_q.push_back(1'b0);
                end
                for (int u = 0; u < DU; u++) unit_q.push_back(1'b0);
            end
            exp_led = (unit_q.size() != 0) ? unit_q.pop_front() : 1'b0;
        end else begin
            pc++;
        end
    end

    // high-run recorder (lengths in clock cycles)
    int hi_runs[$];
    int cur_run = 0;

    task automatic check(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, actual, expected, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            check("R2/R3/R4/R5/R6/R8/R9/R10 per-cycle led", int'(led), int'(exp_led));
            if (led) cur_run++;
            else if (cur_run > 0) begin
                hi_runs.push_back(cur_run);
                cur_run = 0;
            end
        end else begin
            cur_run = 0;
        end
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        wait_cycles(150000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d cycles", cycles, 150000);
        finish_run();
    end

    localparam int FRAME = P * (3 * GU + DU);

    initial begin
        int lit;
        wait_cycles(3);
        check("R1 led off in reset", int'(led), 0);
        rst = 1'b0;

        // R7: flag low, LED must stay dark
        lit = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (led) lit++;
        end
        check("R7 lit cycles while idle", lit, 0);

        // R3: value 0100, third pulse long
        hi_runs.delete();
        code = 4'b0100;
        en = 1'b1;
        wait_cycles(FRAME + 4 * P * LU + 2 * P);
        check("R3 pulse count 0100", (hi_runs.size() >= 4) ? 1 : 0, 1);
        if (hi_runs.size() >= 4) begin
            check("R4 short first pulse 0100", hi_runs[0], SU * P);
            check("R3 long third pulse 0100", hi_runs[2], LU * P);
            check("R4 short fourth pulse 0100", hi_runs[3], SU * P);
        end

        // R3: value 0001, first pulse long
        en = 1'b0;
        wait_cycles(2 * FRAME);
        hi_runs.delete();
        code = 4'b0001;
        en = 1'b1;
        wait_cycles(FRAME + 4 * P * LU + 2 * P);
        check("R3 pulse count 0001", (hi_runs.size() >= 4) ? 1 : 0, 1);
        if (hi_runs.size() >= 4) begin
            check("R3 long first pulse 0001", hi_runs[0], LU * P);
            check("R4 short second pulse 0001", hi_runs[1], SU * P);
        end

        // R8: value changed mid-frame
        en = 1'b0;
        wait_cycles(2 * FRAME);
        hi_runs.delete();
        code = 4'b1111;
        en = 1'b1;
        wait_cycles(3 * P);
        code = 4'b0000;
        wait_cycles(FRAME + 4 * P * LU);
        if (hi_runs.size() >= 4) begin
            check("R8 first frame bit3 kept long", hi_runs[3], LU * P);
            check("R8 first frame bit1 kept long", hi_runs[1], LU * P);
        end else begin
            check("R8 pulse count", hi_runs.size(), 4);
        end

        // R9: flag dropped mid-frame; exactly one frame completes
        en = 1'b0;
        wait_cycles(2 * FRAME);
        hi_runs.delete();
        code = 4'b1001;
        en = 1'b1;
        wait_cycles(4 * P);
        en = 1'b0;
        wait_cycles(3 * FRAME);
        check("R9 pulses after drop", hi_runs.size(), 4);
        check("R9 led idle after drop", int'(led), 0);

        // R6: repeat with value 1010 over two frames
        hi_runs.delete();
        code = 4'b1010;
        en = 1'b1;
        wait_cycles(2 * (FRAME + 4 * P * LU) + 2 * P);
        check("R6 repeated frame pulses", (hi_runs.size() >= 8) ? 1 : 0, 1);
        if (hi_runs.size() >= 8) check("R6 repeat bit1 long", hi_runs[5], LU * P);

        // R1: reset mid-frame
        wait_cycles(5);
        rst = 1'b1;
        @(negedge clk);
        check("R1 led off after mid-frame reset", int'(led), 0);
        rst = 1'b0;
        en = 1'b0;
        wait_cycles(20);
        check("R7 dark after reset with flag low", int'(led), 0);

        finish_run();
    end
endmodule